// File: doc/BRIEF.md
# Execute Stage with Exception Bypass

This block is the execute stage of a five-stage in-order RISC pipeline. Each cycle it takes the bundle produced by decode: an operation code, the two register operands, an extended immediate, an operand-select flag, the register-write enable, a hardware-register selector, the instruction address, an exception cause already raised upstream, and a delay-slot flag. It chooses the second ALU operand and computes the result. It merges any exception that the ALU raises (arithmetic overflow or a trap compare) into the outgoing cause. It captures everything into the execute/memory pipeline register on the clock edge.

An instruction that arrives already carrying an exception is not evaluated. Its result is zero and its cause travels on unchanged, so the first fault in program order is the one reported. A hardware-register read operation returns a value from a small internal set: constants, the cache line size, a free-running cycle counter, and a user-local register that a dedicated port writes. A flush input replaces the captured instruction with a bubble.

Top module: `ex_stage`

## Requirements
- R1: The second ALU operand is `imm_i` when `imm_sel_i` is 1 and `rt_val_i` when it is 0; the first operand is always `rs_val_i`.
- R2: Operation codes 0 ADD, 1 ADDU, 2 SUB, 3 SUBU, 4 AND, 5 OR, 6 XOR, 7 SLT (signed, result 1 or 0) and 8 SLTU (unsigned) produce their 32-bit wrapped result. Codes 18 to 31 produce 0 with cause 0 and leave the write enable unchanged.
- R3: ADD (0) and SUB (2) set the outgoing cause to 4 (overflow) on two's-complement signed overflow; the wrapped result is still delivered. ADDU and SUBU never raise a cause.
- R4: The trap operations have these codes and conditions: 11 TGE (signed a>=b), 12 TGEU (unsigned a>=b), 13 TLT (signed a<b), 14 TLTU (unsigned a<b), 15 TEQ (a==b) and 16 TNE (a!=b). Each produces result 0 and cause 3 when its condition holds, and cause 0 otherwise.
- R5: The conditional moves 9 MOVZ and 10 MOVN return `rs_val_i`. MOVZ clears the outgoing write enable when the second operand is non-zero, and MOVN clears it when the second operand is zero.
- R6: When `cause_i` is non-zero, the result is 0, `cause_o` equals `cause_i`, and `reg_we_o` equals `reg_we_i`, whatever the operation, operands or selector.
- R7: Operation 17 (hardware read) returns a value chosen by `hwr_sel_i`: 0 gives 0, 1 gives LINE_BYTES (default 64), 2 gives the cycle counter, 3 gives 1, 29 gives the user-local register, and any other value gives 0. It raises no cause.
- R8: The cycle counter is 0 in reset and adds 1 on every clock edge after reset. A read returns the counter value held before the edge that captures the instruction.
- R9: The user-local register resets to 0 and loads `ulocal_wdata_i` on an edge where `ulocal_we_i` is 1. A read captured on that same edge returns the old value.
- R10: On the edge after the inputs are applied, `pc_o` and `dslot_o` equal the applied `pc_i` and `dslot_i`.
- R11: A `flush_i` of 1 captures a bubble: `res_o`, `reg_we_o`, `cause_o`, `pc_o` and `dslot_o` all become 0, whatever the other inputs are.
- R12: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Capture a bubble instead of the instruction |
| op_i | input | 5 | Operation code |
| rs_val_i | input | 32 | First register operand |
| rt_val_i | input | 32 | Second register operand |
| imm_i | input | 32 | Extended immediate |
| imm_sel_i | input | 1 | Use the immediate as the second operand |
| reg_we_i | input | 1 | Register-write enable from decode |
| hwr_sel_i | input | 5 | Hardware-register selector |
| pc_i | input | 32 | Instruction address |
| cause_i | input | 3 | Exception cause from earlier stages, 0 = none |
| dslot_i | input | 1 | Instruction sits in a delay slot |
| ulocal_we_i | input | 1 | Write strobe for the user-local register |
| ulocal_wdata_i | input | 32 | Write data for the user-local register |
| res_o | output | 32 | Registered result |
| reg_we_o | output | 1 | Registered write enable |
| cause_o | output | 3 | Registered exception cause |
| pc_o | output | 32 | Registered instruction address |
| dslot_o | output | 1 | Registered delay-slot flag |

## Verification
An exception that comes in from upstream and an exception that the ALU would raise can fall in the same cycle. So can an incoming exception and a conditional-move discard. To provoke these, the bench drives every non-zero incoming cause together with operands that overflow ADD, match TEQ, or make MOVZ discard, and also with hardware reads of the counter. The result is judged correct only if the incoming cause, a zero result and the unchanged write enable appear. A user-local write and a read of that register on the same edge are also combined; the read must return the old value.

// File: rtl/ex_pkg.sv
package ex_pkg;
  localparam int OP_W    = 5;
  localparam int CAUSE_W = 3;
  localparam int SEL_W   = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,  OP_ADDU = 5'd1,  OP_SUB  = 5'd2,  OP_SUBU = 5'd3,
    OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR  = 5'd6,  OP_SLT  = 5'd7,
    OP_SLTU = 5'd8,  OP_MOVZ = 5'd9,  OP_MOVN = 5'd10, OP_TGE  = 5'd11,
    OP_TGEU = 5'd12, OP_TLT  = 5'd13, OP_TLTU = 5'd14, OP_TEQ  = 5'd15,
    OP_TNE  = 5'd16, OP_HWR  = 5'd17
  } alu_op_e;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_SYS   = 3'd1,
    CAUSE_BRK   = 3'd2,
    CAUSE_TRAP  = 3'd3,
    CAUSE_OVFL  = 3'd4,
    CAUSE_HWBRK = 3'd5
  } cause_e;

  localparam logic [SEL_W-1:0] HWR_CPU    = 5'd0;
  localparam logic [SEL_W-1:0] HWR_LINE   = 5'd1;
  localparam logic [SEL_W-1:0] HWR_CYC    = 5'd2;
  localparam logic [SEL_W-1:0] HWR_CYCRES = 5'd3;
  localparam logic [SEL_W-1:0] HWR_ULOCAL = 5'd29;
endpackage

// File: rtl/ex_alu.sv
module ex_alu import ex_pkg::*; #(
  parameter int XLEN = 32
) (
  input  logic [OP_W-1:0]    op_i,
  input  logic [XLEN-1:0]    a_i,
  input  logic [XLEN-1:0]    b_i,
  output logic [XLEN-1:0]    res_o,
  output logic               discard_o,
  output logic [CAUSE_W-1:0] cause_o
);
  localparam int MSB = XLEN - 1;

  logic [XLEN-1:0] sum, dif;
  logic            add_ovf, sub_ovf, lt_s, lt_u, eq;

  assign sum     = a_i + b_i;
  assign dif     = a_i - b_i;
  assign add_ovf = (a_i[MSB] == b_i[MSB]) && (sum[MSB] != a_i[MSB]);
  assign sub_ovf = (a_i[MSB] != b_i[MSB]) && (dif[MSB] != a_i[MSB]);
  assign lt_s    = $signed(a_i) < $signed(b_i);
  assign lt_u    = a_i < b_i;
  assign eq      = a_i == b_i;

  // trap raises cause when its compare holds
  function automatic logic [CAUSE_W-1:0] trap(input logic hit);
    return hit ? CAUSE_TRAP : CAUSE_NONE;
  endfunction

  always_comb begin
    res_o     = '0;
    discard_o = 1'b0;
    cause_o   = CAUSE_NONE;
    case (alu_op_e'(op_i))
      OP_ADD:  begin res_o = sum; if (add_ovf) cause_o = CAUSE_OVFL; end
      OP_ADDU: res_o = sum;
      OP_SUB:  begin res_o = dif; if (sub_ovf) cause_o = CAUSE_OVFL; end
      OP_SUBU: res_o = dif;
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_SLT:  res_o = {{(XLEN-1){1'b0}}, lt_s};
      OP_SLTU: res_o = {{(XLEN-1){1'b0}}, lt_u};
      OP_MOVZ: begin res_o = a_i; discard_o = (b_i != '0); end
      OP_MOVN: begin res_o = a_i; discard_o = (b_i == '0); end
      OP_TGE:  cause_o = trap(!lt_s);
      OP_TGEU: cause_o = trap(!lt_u);
      OP_TLT:  cause_o = trap(lt_s);
      OP_TLTU: cause_o = trap(lt_u);
      OP_TEQ:  cause_o = trap(eq);
      OP_TNE:  cause_o = trap(!eq);
      default: ;
    endcase
  end
endmodule

// File: rtl/ex_hwreg.sv
module ex_hwreg import ex_pkg::*; #(
  parameter int XLEN       = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             ulocal_we_i,
  input  logic [XLEN-1:0]  ulocal_wdata_i,
  output logic [XLEN-1:0]  rdata_o
);
  localparam logic [XLEN-1:0] LINE_VAL = XLEN'(LINE_BYTES);
  localparam logic [XLEN-1:0] ONE      = XLEN'(1);

  logic [XLEN-1:0] cyc_q, ulocal_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else         cyc_q <= cyc_q + ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ulocal_q <= '0;
    else if (ulocal_we_i) ulocal_q <= ulocal_wdata_i;
  end

  always_comb begin
    case (sel_i)
      HWR_LINE:   rdata_o = LINE_VAL;
      HWR_CYC:    rdata_o = cyc_q;
      HWR_CYCRES: rdata_o = ONE;
      HWR_ULOCAL: rdata_o = ulocal_q;
      default:    rdata_o = '0;
    endcase
  end

  assert_cyc_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> cyc_q == $past(cyc_q) + ONE);

  assert_ulocal_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ulocal_we_i |=> ulocal_q == $past(ulocal_wdata_i));
endmodule

// File: rtl/ex_stage.sv
module ex_stage import ex_pkg::*; #(
  parameter int XLEN       = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic [OP_W-1:0]    op_i,
  input  logic [XLEN-1:0]    rs_val_i,
  input  logic [XLEN-1:0]    rt_val_i,
  input  logic [XLEN-1:0]    imm_i,
  input  logic               imm_sel_i,
  input  logic               reg_we_i,
  input  logic [SEL_W-1:0]   hwr_sel_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               dslot_i,
  input  logic               ulocal_we_i,
  input  logic [XLEN-1:0]    ulocal_wdata_i,
  output logic [XLEN-1:0]    res_o,
  output logic               reg_we_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [XLEN-1:0]    pc_o,
  output logic               dslot_o
);
  logic [XLEN-1:0]    opb, alu_res, hwr_rdata, nxt_res;
  logic               alu_discard, nxt_we, exc_in;
  logic [CAUSE_W-1:0] alu_cause, nxt_cause;

  assign opb    = imm_sel_i ? imm_i : rt_val_i;
  assign exc_in = cause_i != CAUSE_NONE;

  ex_alu #(.XLEN(XLEN)) u_alu (
    .op_i      (op_i),
    .a_i       (rs_val_i),
    .b_i       (opb),
    .res_o     (alu_res),
    .discard_o (alu_discard),
    .cause_o   (alu_cause)
  );

  ex_hwreg #(.XLEN(XLEN), .LINE_BYTES(LINE_BYTES)) u_hwreg (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sel_i          (hwr_sel_i),
    .ulocal_we_i    (ulocal_we_i),
    .ulocal_wdata_i (ulocal_wdata_i),
    .rdata_o        (hwr_rdata)
  );

  // upstream fault wins: skip evaluation, keep its cause
  always_comb begin
    nxt_res   = '0;
    nxt_we    = reg_we_i;
    nxt_cause = cause_i;
    if (!exc_in) begin
      nxt_cause = alu_cause;
      nxt_res   = (op_i == OP_HWR) ? hwr_rdata : alu_res;
      if (alu_discard) nxt_we = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || flush_i) begin
      res_o    <= '0;
      reg_we_o <= 1'b0;
      cause_o  <= CAUSE_NONE;
      pc_o     <= '0;
      dslot_o  <= 1'b0;
    end else begin
      res_o    <= nxt_res;
      reg_we_o <= nxt_we;
      cause_o  <= nxt_cause;
      pc_o     <= pc_i;
      dslot_o  <= dslot_i;
    end
  end

  assert_trap_teq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && !exc_in && op_i == OP_TEQ && rs_val_i == opb) |=> cause_o == CAUSE_TRAP);

  assert_exc_bypass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && exc_in) |=> (cause_o == $past(cause_i) && res_o == '0));

  assert_pc_carry_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> (pc_o == $past(pc_i) && dslot_o == $past(dslot_i)));

  assert_flush_bubble_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!reg_we_o && cause_o == CAUSE_NONE && res_o == '0));
endmodule

// File: tb/sim_ex_stage.sv
`timescale 1ns/1ps
module sim_ex_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush, imm_sel, reg_we, dslot, uwe;
  logic [4:0]  op, hsel;
  logic [2:0]  cause;
  logic [31:0] rs, rt, imm, pc, uwd;
  logic [31:0] res_o, pc_o;
  logic        we_o, dslot_o;
  logic [2:0]  cause_o;

  int unsigned nchk = 0, nfail = 0;
  logic [31:0] cyc_m;

  always #2 clk = ~clk;

  ex_stage u0 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .op_i(op),
    .rs_val_i(rs), .rt_val_i(rt), .imm_i(imm), .imm_sel_i(imm_sel),
    .reg_we_i(reg_we), .hwr_sel_i(hsel), .pc_i(pc), .cause_i(cause),
    .dslot_i(dslot), .ulocal_we_i(uwe), .ulocal_wdata_i(uwd),
    .res_o(res_o), .reg_we_o(we_o), .cause_o(cause_o), .pc_o(pc_o),
    .dslot_o(dslot_o)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc_m <= '0;
    else        cyc_m <= cyc_m + 32'd1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic edge_sample();
    @(posedge clk); #1;
  endtask

  function automatic void model(input int o, input logic [31:0] s, input logic [31:0] t,
                                input logic we_in, output logic [31:0] r,
                                output logic we, output logic [2:0] c);
    logic [31:0] x;
    r = 0; we = we_in; c = 0;
    case (o)
      0: begin x = s + t; r = x; if (s[31] == t[31] && x[31] != s[31]) c = 4; end
      1: r = s + t;
      2: begin x = s - t; r = x; if (s[31] != t[31] && x[31] != s[31]) c = 4; end
      3: r = s - t;
      4: r = s & t;
      5: r = s | t;
      6: r = s ^ t;
      7: r = ($signed(s) < $signed(t)) ? 1 : 0;
      8: r = (s < t) ? 1 : 0;
      9: begin r = s; if (t != 0) we = 0; end
      10: begin r = s; if (t == 0) we = 0; end
      11: c = ($signed(s) >= $signed(t)) ? 3 : 0;
      12: c = (s >= t) ? 3 : 0;
      13: c = ($signed(s) < $signed(t)) ? 3 : 0;
      14: c = (s < t) ? 3 : 0;
      15: c = (s == t) ? 3 : 0;
      16: c = (s != t) ? 3 : 0;
      default: ;
    endcase
  endfunction

  function automatic string req_of(input int o, input logic [2:0] c);
    if (o <= 3 && c == 4) return "R3";
    if (o >= 11 && o <= 16) return "R4";
    if (o == 9 || o == 10) return "R5";
    return "R2";
  endfunction

  initial begin
    #400000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] vals [8];
    logic [31:0] er, ulm;
    logic        ew;
    logic [2:0]  ec;
    vals[0] = 32'h0;        vals[1] = 32'h1;        vals[2] = 32'h4;
    vals[3] = 32'h7FFFFFFF; vals[4] = 32'h80000000; vals[5] = 32'h80000003;
    vals[6] = 32'hFFFFFFFF; vals[7] = 32'h12345678;
    flush = 0; imm_sel = 0; reg_we = 1; dslot = 1; uwe = 0; op = 0; hsel = 0;
    cause = 0; rs = 32'h1; rt = 32'h2; imm = 0; pc = 32'hDEAD0000; uwd = 0;
    ulm = 0;
    repeat (3) edge_sample();
    chk("R12 res", res_o, 0);
    chk("R12 we", {31'b0, we_o}, 0);
    chk("R12 cause", {29'b0, cause_o}, 0);
    chk("R12 pc", pc_o, 0);
    chk("R12 dslot", {31'b0, dslot_o}, 0);
    @(negedge clk); rst_n = 1;

    // main sweep: ops x operand pairs x operand select
    for (int o = 0; o < 20; o++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          for (int s = 0; s < 2; s++) begin
            logic [31:0] b;
            string tag;
            @(negedge clk);
            op = (o == 19) ? 5'd31 : 5'(o);
            rs = vals[i];
            imm_sel = s[0];
            if (s == 1) begin imm = vals[j]; rt = vals[(j + 3) % 8]; end
            else begin rt = vals[j]; imm = vals[(j + 5) % 8]; end
            b = vals[j];
            reg_we = ((i + j) % 3) != 0;
            dslot = j[0];
            pc = {16'hA000, 8'(o), 4'(i), 4'(j)};
            hsel = 0; cause = 0;
            model(op, rs, b, reg_we, er, ew, ec);
            tag = $sformatf("%s op%0d", (s == 1) ? "R1" : req_of(o, ec), o);
            edge_sample();
            chk(tag, res_o, er);
            chk(tag, {31'b0, we_o}, {31'b0, ew});
            chk(tag, {29'b0, cause_o}, {29'b0, ec});
            chk("R10 pc", pc_o, pc);
            chk("R10 dslot", {31'b0, dslot_o}, {31'b0, dslot});
          end
        end
      end
    end

    // incoming exception collides with ALU-raised cause / discard / hw read
    for (int c = 1; c < 8; c++) begin
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        cause = 3'(c); imm_sel = 0; reg_we = k[0]; hsel = 5'd2;
        case (k)
          0: begin op = 5'd0;  rs = 32'h7FFFFFFF; rt = 32'h1; end
          1: begin op = 5'd15; rs = 32'h55;       rt = 32'h55; end
          2: begin op = 5'd9;  rs = 32'h77;       rt = 32'h3; end
          3: begin op = 5'd17; rs = 32'h1;        rt = 32'h1; end
          default: begin op = 5'd2; rs = 32'h80000003; rt = 32'h4; end
        endcase
        edge_sample();
        chk($sformatf("R6 res c%0d k%0d", c, k), res_o, 0);
        chk("R6 cause", {29'b0, cause_o}, {29'b0, 3'(c)});
        chk("R6 we", {31'b0, we_o}, {31'b0, reg_we});
      end
    end

    // hardware read sweep over all selectors
    for (int s = 0; s < 32; s++) begin
      @(negedge clk);
      cause = 0; op = 5'd17; hsel = 5'(s); reg_we = 1; rs = 32'h9; rt = 32'h9;
      edge_sample();
      case (s)
        1: er = 32'd64;
        2: er = cyc_m - 32'd1;
        3: er = 32'd1;
        29: er = ulm;
        default: er = 0;
      endcase
      chk($sformatf("%s sel%0d", (s == 2) ? "R8" : "R7", s), res_o, er);
      chk("R7 cause", {29'b0, cause_o}, 0);
    end

    // back-to-back counter reads
    for (int n = 0; n < 3; n++) begin
      @(negedge clk); op = 5'd17; hsel = 5'd2;
      edge_sample();
      chk("R8 cycle", res_o, cyc_m - 32'd1);
    end

    // user-local write and read on the same edge
    @(negedge clk); op = 5'd17; hsel = 5'd29; uwe = 1; uwd = 32'hA5A5C3C3;
    edge_sample();
    chk("R9 same-edge old", res_o, ulm);
    ulm = 32'hA5A5C3C3;
    @(negedge clk); uwe = 0; uwd = 32'h0;
    edge_sample();
    chk("R9 new value", res_o, ulm);
    @(negedge clk); uwe = 1; uwd = 32'h0BADF00D; hsel = 5'd0;
    edge_sample();
    chk("R9 other sel", res_o, 0);
    ulm = 32'h0BADF00D;
    @(negedge clk); uwe = 0; hsel = 5'd29;
    edge_sample();
    chk("R9 second write", res_o, ulm);

    // flush over live instructions
    for (int f = 0; f < 4; f++) begin
      @(negedge clk);
      flush = 1; reg_we = 1; dslot = 1; pc = 32'hFFFF0000 + f;
      op = (f == 0) ? 5'd15 : 5'd1; rs = 32'h3; rt = 32'h3;
      cause = (f == 2) ? 3'd5 : 3'd0;
      if (f == 3) begin op = 5'd17; hsel = 5'd3; end
      edge_sample();
      chk("R11 res", res_o, 0);
      chk("R11 we", {31'b0, we_o}, 0);
      chk("R11 cause", {29'b0, cause_o}, 0);
      chk("R11 pc", pc_o, 0);
      chk("R11 dslot", {31'b0, dslot_o}, 0);
    end
    @(negedge clk); flush = 0; op = 5'd1; cause = 0; rs = 32'h10; rt = 32'h20; imm_sel = 0;
    edge_sample();
    chk("R11 recover", res_o, 32'h30);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule